// File: doc/BRIEF.md
# Colour Lookup Palette with Byte-Serial Loading

This block holds a 256-entry colour lookup table. Each entry has a red, a green and a blue 8-bit component. Software reaches the table through a 32-bit register port that has two registers. The first is an index register that selects an entry. The second is a colour data register that moves one component per bus access. Only the most significant byte lane of the bus word carries payload. An internal pointer steps through the red, green and blue components of an entry and then moves to the next entry. A single index write can therefore be followed by a long run of data accesses that fills, or dumps, many consecutive entries.

The pixel side accepts one 26-bit stored pixel per clock. The top two bits of the pixel are a per-pixel mode field. The other 24 bits hold three colour bytes. Depending on the mode, the pixel is resolved in one of three ways:
- as an 8-bit index into the table,
- as three bytes that each pass through their own component column of the table,
- as direct colour that bypasses the table.

The final RGB value is registered, so it appears one clock after the pixel is presented.

Top module: `pal_dac`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `red_out`, `grn_out`, `blu_out` and `reg_rdata` are zero. The load pointer starts at entry 0, component red, so a data write with no prior index write lands in the red component of entry 0.
- R2: A write with `reg_sel` = 0 (index register) loads the entry index from `reg_wdata[31:24]` and ignores bits 23:0. It also returns the component pointer to red, even in the middle of an entry.
- R3: A write with `reg_sel` = 1 (colour data register) stores `reg_wdata[31:24]` into the current component of the current entry and ignores bits 23:0. Successive data writes fill red, then green, then blue. After blue, the pointer goes back to red and the index increments, wrapping from 255 to 0.
- R4: A read with `reg_sel` = 1 returns the current component in `reg_rdata[31:24]` with bits 23:0 zero, on the clock after the read strobe. The pointer advances exactly as it does for a data write.
- R5: A read with `reg_sel` = 0 returns the current entry index in `reg_rdata[31:24]`, with bits 23:0 zero, on the clock after the strobe. The pointer does not move.
- R6: `pix_in[25:24]` is the mode, and `pix_in[23:16]`, `[15:8]` and `[7:0]` are red, green and blue. Mode 0 outputs all three components of the entry indexed by `pix_in[7:0]`.
- R7: Mode 2 behaves exactly like mode 0.
- R8: In mode 1, red is looked up in the red column at index `pix_in[23:16]`, green in the green column at `pix_in[15:8]`, and blue in the blue column at `pix_in[7:0]`.
- R9: In mode 3, the colour bytes are output unchanged and the table is not used.
- R10: The pixel output is registered with one clock of latency. A pixel presented in the cycle right after a table write already sees the new component value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (ignored when `reg_wr` is high) |
| reg_sel | input | 1 | 0 = index register, 1 = colour data register |
| reg_wdata | input | 32 | Write data; payload in bits 31:24 |
| reg_rdata | output | 32 | Read data; payload in bits 31:24, rest zero |
| pix_in | input | 26 | Mode in 25:24, red 23:16, green 15:8, blue 7:0 |
| red_out | output | 8 | Registered red result |
| grn_out | output | 8 | Registered green result |
| blu_out | output | 8 | Registered blue result |

## Verification
The bench fills all 768 component slots after one index write, so the pointer must wrap from entry 255 back to 0. A design that failed to wrap, or that stepped the index after the wrong component, would leave the wrong entry in place when the next index is read back. Index writes in the middle of an entry check that the component pointer goes back to red; a design that kept the old phase would put the byte into green. Pixels placed right after single-component writes catch a stale lookup or an extra pipeline stage. Mode 1 pixels with three different bytes catch a design that uses one shared index, and mode 2 catches a decoder that treats it as direct colour.

// File: rtl/pal_pkg.sv
package pal_pkg;
    localparam int COMP_W   = 8;
    localparam int IDX_W    = 8;
    localparam int NUM_ENT  = 1 << IDX_W;
    localparam int NUM_COMP = 3;
    localparam int BUS_W    = 32;
    localparam int COLOR_W  = NUM_COMP * COMP_W;
    localparam int MODE_W   = 2;
    localparam int PIX_W    = COLOR_W + MODE_W;

    typedef enum logic [1:0] {
        COMP_RED = 2'd0,
        COMP_GRN = 2'd1,
        COMP_BLU = 2'd2
    } comp_e;

    typedef enum logic [MODE_W-1:0] {
        PM_INDEX     = 2'd0,
        PM_MAPPED    = 2'd1,
        PM_INDEX_ALT = 2'd2,
        PM_DIRECT    = 2'd3
    } pmode_e;

    typedef struct packed {
        logic [COMP_W-1:0] red;
        logic [COMP_W-1:0] grn;
        logic [COMP_W-1:0] blu;
    } rgb_t;

    function automatic comp_e next_comp(comp_e c);
        case (c)
            COMP_RED: return COMP_GRN;
            COMP_GRN: return COMP_BLU;
            default:  return COMP_RED;
        endcase
    endfunction
endpackage

// File: rtl/pal_table.sv
module pal_table
    import pal_pkg::*;
(
    input  logic                              clk,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  comp_e                             wr_comp,
    input  logic [COMP_W-1:0]                 wr_val,
    input  logic [NUM_COMP-1:0][IDX_W-1:0]    pix_idx,
    output logic [NUM_COMP-1:0][COMP_W-1:0]   pix_val,
    input  logic [IDX_W-1:0]                  rb_idx,
    input  comp_e                             rb_comp,
    output logic [COMP_W-1:0]                 rb_val
);
    logic [NUM_COMP-1:0][COMP_W-1:0] rb_lane;

    for (genvar c = 0; c < NUM_COMP; c++) begin : g_lane
        logic [COMP_W-1:0] mem [NUM_ENT];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_comp == comp_e'(c)))
                mem[wr_idx] <= wr_val;
        end

        assign pix_val[c] = mem[pix_idx[c]];
        assign rb_lane[c] = mem[rb_idx];
    end

    always_comb begin
        case (rb_comp)
            COMP_RED: rb_val = rb_lane[0];
            COMP_GRN: rb_val = rb_lane[1];
            default:  rb_val = rb_lane[2];
        endcase
    end
endmodule

// File: rtl/pal_loader.sv
module pal_loader
    import pal_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic               reg_sel,
    input  logic [BUS_W-1:0]   reg_wdata,
    output logic [BUS_W-1:0]   reg_rdata,
    output logic               tbl_we,
    output logic [IDX_W-1:0]   ptr_idx,
    output comp_e              ptr_comp,
    output logic [COMP_W-1:0]  tbl_val,
    input  logic [COMP_W-1:0]  rb_val
);
    localparam logic SEL_DATA = 1'b1;
    localparam int   LANE_LO  = BUS_W - COMP_W;
    localparam int   IDX_LO   = BUS_W - IDX_W;

    logic [IDX_W-1:0] idx_q;
    comp_e            comp_q;
    logic             data_wr, addr_wr, data_rd, addr_rd, step;

    assign data_wr = reg_wr && (reg_sel == SEL_DATA);
    assign addr_wr = reg_wr && (reg_sel != SEL_DATA);
    assign data_rd = reg_rd && !reg_wr && (reg_sel == SEL_DATA);
    assign addr_rd = reg_rd && !reg_wr && (reg_sel != SEL_DATA);
    assign step    = data_wr || data_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q     <= '0;
            comp_q    <= COMP_RED;
            reg_rdata <= '0;
        end else begin
            if (addr_wr) begin
                idx_q  <= reg_wdata[BUS_W-1 -: IDX_W];
                comp_q <= COMP_RED;
            end else if (step) begin
                comp_q <= next_comp(comp_q);
                if (comp_q == COMP_BLU)
                    idx_q <= idx_q + {{(IDX_W-1){1'b0}}, 1'b1};
            end
            if (data_rd)
                reg_rdata <= {rb_val, {LANE_LO{1'b0}}};
            else if (addr_rd)
                reg_rdata <= {idx_q, {IDX_LO{1'b0}}};
        end
    end

    assign tbl_we   = data_wr;
    assign tbl_val  = reg_wdata[BUS_W-1 -: COMP_W];
    assign ptr_idx  = idx_q;
    assign ptr_comp = comp_q;
endmodule

// File: rtl/pal_pixel.sv
module pal_pixel
    import pal_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic [PIX_W-1:0]                 pix_in,
    output logic [NUM_COMP-1:0][IDX_W-1:0]   lut_idx,
    input  logic [NUM_COMP-1:0][COMP_W-1:0]  lut_val,
    output rgb_t                             rgb_q
);
    pmode_e mode;
    rgb_t   raw;
    rgb_t   nxt;

    assign mode = pmode_e'(pix_in[PIX_W-1 -: MODE_W]);
    assign raw  = rgb_t'(pix_in[COLOR_W-1:0]);

    always_comb begin
        if (mode == PM_MAPPED) begin
            lut_idx[0] = raw.red;
            lut_idx[1] = raw.grn;
            lut_idx[2] = raw.blu;
        end else begin
            lut_idx[0] = raw.blu;
            lut_idx[1] = raw.blu;
            lut_idx[2] = raw.blu;
        end
    end

    always_comb begin
        if (mode == PM_DIRECT) begin
            nxt = raw;
        end else begin
            nxt.red = lut_val[0];
            nxt.grn = lut_val[1];
            nxt.blu = lut_val[2];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rgb_q <= '0;
        else     rgb_q <= nxt;
    end
endmodule

// File: rtl/pal_dac.sv
module pal_dac
    import pal_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic               reg_sel,
    input  logic [BUS_W-1:0]   reg_wdata,
    output logic [BUS_W-1:0]   reg_rdata,
    input  logic [PIX_W-1:0]   pix_in,
    output logic [COMP_W-1:0]  red_out,
    output logic [COMP_W-1:0]  grn_out,
    output logic [COMP_W-1:0]  blu_out
);
    logic                            tbl_we;
    logic [IDX_W-1:0]                ptr_idx;
    comp_e                           ptr_comp;
    logic [COMP_W-1:0]               tbl_val;
    logic [COMP_W-1:0]               rb_val;
    logic [NUM_COMP-1:0][IDX_W-1:0]  lut_idx;
    logic [NUM_COMP-1:0][COMP_W-1:0] lut_val;
    rgb_t                            rgb_q;

    pal_loader u_loader (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .tbl_we    (tbl_we),
        .ptr_idx   (ptr_idx),
        .ptr_comp  (ptr_comp),
        .tbl_val   (tbl_val),
        .rb_val    (rb_val)
    );

    pal_table u_table (
        .clk     (clk),
        .wr_en   (tbl_we),
        .wr_idx  (ptr_idx),
        .wr_comp (ptr_comp),
        .wr_val  (tbl_val),
        .pix_idx (lut_idx),
        .pix_val (lut_val),
        .rb_idx  (ptr_idx),
        .rb_comp (ptr_comp),
        .rb_val  (rb_val)
    );

    pal_pixel u_pixel (
        .clk     (clk),
        .rst     (rst),
        .pix_in  (pix_in),
        .lut_idx (lut_idx),
        .lut_val (lut_val),
        .rgb_q   (rgb_q)
    );

    assign red_out = rgb_q.red;
    assign grn_out = rgb_q.grn;
    assign blu_out = rgb_q.blu;
endmodule

// File: rtl/pal_dac_chk.sv
module pal_dac_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic        reg_sel,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic [25:0] pix_in,
    input logic [7:0]  red_out,
    input logic [7:0]  grn_out,
    input logic [7:0]  blu_out,
    input logic [7:0]  ptr_idx,
    input logic [1:0]  ptr_comp
);
    // R2: index write loads top byte and restarts at red
    a_r2_index_load: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_sel) |=> (ptr_idx == $past(reg_wdata[31:24]) && ptr_comp == 2'd0));

    // R3: data write after blue moves to next entry, red
    a_r3_entry_advance: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel && ptr_comp == 2'd2) |=> (ptr_idx == $past(ptr_idx) + 8'd1 && ptr_comp == 2'd0));

    // R3: data write before blue steps component only
    a_r3_comp_step: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel && ptr_comp != 2'd2) |=> (ptr_idx == $past(ptr_idx) && ptr_comp == $past(ptr_comp) + 2'd1));

    // R3: component pointer never takes the unused code
    a_r3_comp_legal: assert property (@(posedge clk) disable iff (rst)
        ptr_comp != 2'd3);

    // R5: index read returns index and leaves pointer alone
    a_r5_index_read: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !reg_wr && !reg_sel) |=> (reg_rdata == {$past(ptr_idx), 24'h0} && $stable(ptr_idx) && $stable(ptr_comp)));

    // R9: direct mode passes colour bytes through
    a_r9_direct_pass: assert property (@(posedge clk) disable iff (rst)
        (pix_in[25:24] == 2'd3) |=> ({red_out, grn_out, blu_out} == $past(pix_in[23:0])));
endmodule

bind pal_dac pal_dac_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pix_in    (pix_in),
    .red_out   (red_out),
    .grn_out   (grn_out),
    .blu_out   (blu_out),
    .ptr_idx   (ptr_idx),
    .ptr_comp  (ptr_comp)
);

// File: tb/pal_dac_bench.sv
`timescale 1ns/1ps
module pal_dac_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [25:0] pix_in = '0;
    logic [7:0]  red_out, grn_out, blu_out;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    logic [7:0] m_tab [3][256];
    int         m_idx  = 0;
    int         m_comp = 0;

    always #10 clk = ~clk;

    pal_dac u_pal_dac (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pix_in    (pix_in),
        .red_out   (red_out),
        .grn_out   (grn_out),
        .blu_out   (blu_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_step();
        m_comp++;
        if (m_comp == 3) begin
            m_comp = 0;
            m_idx  = (m_idx + 1) % 256;
        end
    endtask

    function automatic logic [23:0] exp_rgb(input logic [25:0] p);
        logic [7:0] r, g, b;
        r = p[23:16]; g = p[15:8]; b = p[7:0];
        case (p[25:24])
            2'd3:    return {r, g, b};
            2'd1:    return {m_tab[0][r], m_tab[1][g], m_tab[2][b]};
            default: return {m_tab[0][b], m_tab[1][b], m_tab[2][b]};
        endcase
    endfunction

    // called at a falling edge; returns at the next falling edge
    task automatic bus_wr(input logic sel, input logic [31:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = $urandom;
        if (!sel) begin
            m_idx = int'(d[31:24]); m_comp = 0;
        end else begin
            m_tab[m_comp][m_idx] = d[31:24];
            model_step();
        end
    endtask

    task automatic bus_rd(input logic sel, input string req);
        logic [31:0] exp;
        reg_rd = 1'b1; reg_sel = sel;
        @(negedge clk);
        reg_rd = 1'b0;
        if (sel) begin
            exp = {m_tab[m_comp][m_idx], 24'h0};
            model_step();
        end else begin
            exp = {8'(m_idx), 24'h0};
        end
        check(req, reg_rdata, exp);
    endtask

    task automatic pix_chk(input logic [25:0] p, input string req);
        pix_in = p;
        @(negedge clk);
        check(req, {8'h0, red_out, grn_out, blu_out}, {8'h0, exp_rgb(p)});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1", {8'h0, red_out, grn_out, blu_out}, 32'h0);
        check("R1", reg_rdata, 32'h0);

        // R1: pointer starts at entry 0, red
        bus_wr(1'b1, 32'hAB5A5A5A);
        pix_in = 26'h0000000;
        @(negedge clk);
        check("R1", {24'h0, red_out}, 32'h000000AB);

        // R3: fill all 768 slots after one index write, wrap to 0
        bus_wr(1'b0, 32'h00C0FFEE);
        for (int i = 0; i < 768; i++) bus_wr(1'b1, $urandom);
        bus_rd(1'b0, "R3");

        // R6..R9: random pixels
        for (int i = 0; i < 300; i++) begin
            logic [25:0] p;
            p = 26'($urandom);
            case (p[25:24])
                2'd0: pix_chk(p, "R6");
                2'd1: pix_chk(p, "R8");
                2'd2: pix_chk(p, "R7");
                default: pix_chk(p, "R9");
            endcase
        end
        pix_chk(26'h20000FF, "R7");
        pix_chk(26'h000FF00, "R6");
        pix_chk(26'h100FF80, "R8");
        pix_chk(26'h1123456, "R8");
        pix_chk(26'h3FFFFFF, "R9");
        pix_chk(26'h3000000, "R9");

        // R4: data readback across the 255 -> 0 wrap
        bus_wr(1'b0, 32'hFE123456);
        for (int i = 0; i < 9; i++) bus_rd(1'b1, "R4");
        bus_rd(1'b0, "R4");

        // R5: index reads do not move the pointer
        bus_wr(1'b0, 32'h40000000);
        bus_rd(1'b1, "R5");
        bus_rd(1'b0, "R5");
        bus_rd(1'b0, "R5");
        bus_rd(1'b1, "R5");

        // R2: index write mid-entry restarts at red
        bus_wr(1'b0, 32'h05FFFFFF);
        bus_wr(1'b1, 32'h11000000);
        bus_wr(1'b0, 32'h06000000);
        bus_wr(1'b1, 32'h22ABCDEF);
        pix_chk(26'h0000006, "R2");
        pix_chk(26'h0000005, "R2");
        bus_rd(1'b1, "R2");

        // R10: each component write visible on the next pixel
        bus_wr(1'b0, 32'h2A000000);
        bus_wr(1'b1, 32'h3C000000);
        pix_chk(26'h000002A, "R10");
        bus_wr(1'b1, 32'h7E000000);
        pix_chk(26'h200002A, "R10");
        bus_wr(1'b1, 32'hC3000000);
        pix_chk(26'h12A2A2A, "R10");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule